// File: doc/BRIEF.md
# Dual-Source Serial Baud Tick Generator

This block produces the bit-slot enable for a serial port's transmitter and receiver. A single configuration word selects the reference source, enables or disables the programmed rate, and holds a 23-bit divisor N. The block runs on one clock. Each source gets its own fixed prescale enable: divide-by-3 for the crystal source and divide-by-4 for the standard source. The divisor counter then counts N+1 of those prescale enables for each output tick. This covers baud rates from 50 to 4,000,000 across typical reference clocks.

Software programs the word only while the transmitter is idle, meaning its FIFO is empty and no frame is in flight. Every write restarts both counters, so the new rate starts from a clean period. When the enable bit is clear, the output stays low.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the configuration word reads as zero and `bit_tick` is low.
- R2: Word layout: bits 22:0 hold divisor N, bit 23 enables the programmed rate, and bit 24 selects the crystal source when set. Bits 31:25 are ignored on write and read back as zero.
- R3: While the enable bit is clear, `bit_tick` stays low whatever the divisor and source bits hold.
- R4: With the crystal source selected, ticks are spaced exactly 3*(N+1) clock cycles apart.
- R5: With the standard source selected, ticks are spaced exactly 4*(N+1) clock cycles apart.
- R6: A write resets both counters at the edge that captures it. The first tick then rises exactly one full period later, counted in clock edges from that capture edge, and any partial period from before the write is discarded.
- R7: Each tick lasts exactly one clock cycle.
- R8: Tick spacing stays constant over many consecutive periods, so the rate does not drift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| bit_tick | output | 1 | One-cycle bit-slot enable |

## Verification
The bench sweeps the divisor from 0 to 7 with both sources selected. It measures the delay from the write to the first tick and the gap to the second tick. This separates the prescale factor (3 or 4) from the N+1 counter length, and catches off-by-one errors in either counter. A large divisor run over several consecutive periods shows whether the spacing drifts. A write that restarts the counter mid-period, a disabled configuration, and an all-ones write show whether the restart works, whether the enable gates the output, and whether the unused bits are masked.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W    = 23,
  parameter int XTAL_DIV = 3,
  parameter int STD_DIV  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        bit_tick
);
  localparam int EN_BIT  = DIV_W;
  localparam int SRC_BIT = DIV_W + 1;
  localparam int PRE_MAX = (XTAL_DIV > STD_DIV) ? XTAL_DIV : STD_DIV;
  localparam int PRE_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam logic [PRE_W-1:0] XTAL_LAST = PRE_W'(XTAL_DIV - 1);
  localparam logic [PRE_W-1:0] STD_LAST  = PRE_W'(STD_DIV - 1);

  logic [SRC_BIT:0]  cfg_q;
  logic [PRE_W-1:0]  pre_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic              tick_q;
  logic              pre_last, div_last;

  wire unused_hi = ^cfg_wdata[31:SRC_BIT+1];

  assign pre_last  = pre_cnt == (cfg_q[SRC_BIT] ? XTAL_LAST : STD_LAST);
  assign div_last  = div_cnt == cfg_q[DIV_W-1:0];
  assign cfg_rdata = {{(31-SRC_BIT){1'b0}}, cfg_q};
  assign bit_tick  = tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      pre_cnt <= '0;
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (cfg_we) begin
      cfg_q   <= cfg_wdata[SRC_BIT:0];
      pre_cnt <= '0;
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (!cfg_q[EN_BIT]) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= pre_last && div_last;
      if (pre_last) begin
        pre_cnt <= '0;
        div_cnt <= div_last ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

module baud_tick_gen_chk #(
  parameter int DIV_W    = 23,
  parameter int XTAL_DIV = 3,
  parameter int STD_DIV  = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_rdata,
  input logic        bit_tick
);
  logic [31:0] gap;
  logic [31:0] period;

  assign period = (cfg_rdata[DIV_W+1] ? 32'(XTAL_DIV) : 32'(STD_DIV))
                * (32'(cfg_rdata[DIV_W-1:0]) + 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n)        gap <= '0;
    else if (cfg_we)   gap <= '0;
    else if (bit_tick) gap <= 32'd1;
    else               gap <= gap + 32'd1;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:DIV_W+2] == '0);
  assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[DIV_W] |-> !bit_tick);
  assert_write_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !bit_tick);
  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
  assert_even_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> gap == period);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .DIV_W(DIV_W), .XTAL_DIV(XTAL_DIV), .STD_DIV(STD_DIV)
) chk_i (.*);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bit_tick;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic wait_tick(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (bit_tick) break;
    end
  endtask

  function automatic logic [31:0] cfg_word(input bit xtal, input bit en, input int n);
    return {7'd0, xtal, en, 23'(n)};
  endfunction

  initial begin
    int k;
    int per;
    int hi;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_rdata == 32'd0, "R1 cfg", int'(cfg_rdata), 0);
    check(!bit_tick, "R1 tick", int'(bit_tick), 0);

    write_cfg(32'hFFFF_FFFF);
    @(negedge clk);
    check(cfg_rdata == 32'h01FF_FFFF, "R2 mask", int'(cfg_rdata), 32'h01FF_FFFF);

    write_cfg(cfg_word(1'b0, 1'b0, 1));
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bit_tick) hi++;
    end
    check(hi == 0, "R3 off std", hi, 0);
    write_cfg(cfg_word(1'b1, 1'b0, 0));
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bit_tick) hi++;
    end
    check(hi == 0, "R3 off xtal", hi, 0);

    for (int src = 0; src < 2; src++) begin
      for (int n = 0; n < 8; n++) begin
        per = (src == 1 ? 3 : 4) * (n + 1);
        write_cfg(cfg_word(src[0], 1'b1, n));
        wait_tick(per + 10, k);
        check(k == per, src == 1 ? "R4 R6 first" : "R5 R6 first", k, per);
        wait_tick(per + 10, k);
        check(k == per, src == 1 ? "R4 gap" : "R5 gap", k, per);
        @(negedge clk);
        check(!bit_tick, "R7 width", int'(bit_tick), 0);
      end
    end

    per = 4 * 6;
    write_cfg(cfg_word(1'b0, 1'b1, 5));
    repeat (per - 5) @(negedge clk);
    write_cfg(cfg_word(1'b0, 1'b1, 5));
    wait_tick(per + 10, k);
    check(k == per, "R6 restart", k, per);

    per = 3 * 1000;
    write_cfg(cfg_word(1'b1, 1'b1, 999));
    wait_tick(per + 10, k);
    check(k == per, "R8 first", k, per);
    for (int i = 0; i < 5; i++) begin
      wait_tick(per + 10, k);
      check(k == per, "R8 long", k, per);
    end

    write_cfg(cfg_word(1'b1, 1'b0, 999));
    @(negedge clk);
    check(!bit_tick, "R3 disable", int'(bit_tick), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule